// File: doc/BRIEF.md
# Channel Interrupt Status Aggregator

The block gathers completion and fault events from 64 data channels into two 32-bit pending-interrupt registers. It raises interrupt request lines toward a host processor. Each channel supplies a one-cycle done pulse and a one-cycle error pulse. Either pulse marks that channel as pending. The host inspects and acknowledges the pending bits through a small register port, which has an address, write data, a write strobe, a read strobe and combinational read data.

Two static control inputs choose how the block behaves. The clear-mode input picks between two ways of acknowledging a bit. In one, reading a register acknowledges the bits it returns. In the other, the host acknowledges a bit by writing a one to it. The merge input folds both request lines onto the first output, for hosts that wire up only a single interrupt. Both inputs may change at run time. A pending bit is never lost to a clear that lands in the same cycle as a new event.

Top module: `chan_irq_status`

## Requirements
- R1: Two status registers exist. The low register is at address 0x3D0, and its bit n is channel n. The high register is at address 0x3D4, and its bit n is channel 32+n. Reset sets both registers to zero, and both request lines are low after reset.
- R2: A done pulse or an error pulse on a channel at a clock edge sets that channel's status bit. The bit reads back as 1 in the cycle after that edge.
- R3: With the merge input at 0, irq0 is high exactly when a low-register bit is pending. Likewise, irq1 is high exactly when a high-register bit is pending.
- R4: With the merge input at 1, irq0 is high when any bit in either register is pending, and irq1 stays low.
- R5: With the clear-mode input at 0 (clear on read), a read strobe clears at that edge exactly the bits shown on the read data. The register reads zero afterwards unless new events arrived.
- R6: With the clear-mode input at 0, writes to the status registers change nothing.
- R7: With the clear-mode input at 1 (write one to clear), each written 1 clears its status bit. Written zeros have no effect, and reads do not clear anything.
- R8: When a set event and a clear hit the same bit in the same cycle, the bit stays set. This holds for both clear modes.
- R9: Reads of any address other than 0x3D0 and 0x3D4 return zero. Writes to any such address change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 64 | Per-channel done pulse, bit n = channel n |
| err_i | input | 64 | Per-channel error pulse, bit n = channel n |
| addr | input | 12 | Register address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; in clear-on-read mode it acknowledges the returned bits |
| rdata | output | 32 | Read data for addr, combinational |
| clr_mode | input | 1 | 0: clear on read, 1: write one to clear |
| merge_irq | input | 1 | 1: both registers drive irq0, and irq1 is held low |
| irq0 | output | 1 | Interrupt request for the low register (or for both when merged) |
| irq1 | output | 1 | Interrupt request for the high register |

## Verification
The assertions check several rules on every cycle:
- every event pulse is present in the status one cycle later;
- a pending bit never drops unless a read or a write happened;
- the request lines follow the pending state, including the merged case;
- unmapped addresses read zero.

They also check, at each single cycle, the clear behaviour of a clear-on-read access and of a write-one-to-clear access. Only the bench's scenarios show the following:
- that a written zero leaves bits alone, and that writes are ignored in clear-on-read mode;
- that an event landing on a bit being cleared survives;
- that channel numbers map to the right register and bit.

// File: rtl/chan_irq_status.sv
module chan_irq_status #(
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 12'h3D0,
  parameter logic [ADDR_W-1:0] HI_ADDR = 12'h3D4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*REG_W-1:0]   done_i,
  input  logic [2*REG_W-1:0]   err_i,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [REG_W-1:0]     rdata,
  input  logic                 clr_mode,
  input  logic                 merge_irq,
  output logic                 irq0,
  output logic                 irq1
);
  localparam int NCH = 2 * REG_W;

  logic [REG_W-1:0] stat_lo, stat_hi;
  logic [REG_W-1:0] clr_lo, clr_hi;
  logic [NCH-1:0]   ev;
  logic             sel_lo, sel_hi;

  assign ev     = done_i | err_i;
  assign sel_lo = (addr == LO_ADDR);
  assign sel_hi = (addr == HI_ADDR);

  assign rdata = sel_lo ? stat_lo : sel_hi ? stat_hi : '0;

  always_comb begin
    clr_lo = '0;
    clr_hi = '0;
    if (!clr_mode && rd_en) begin
      if (sel_lo) clr_lo = stat_lo;
      if (sel_hi) clr_hi = stat_hi;
    end else if (clr_mode && wr_en) begin
      if (sel_lo) clr_lo = wdata;
      if (sel_hi) clr_hi = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_lo <= '0;
      stat_hi <= '0;
    end else begin
      stat_lo <= (stat_lo & ~clr_lo) | ev[REG_W-1:0];
      stat_hi <= (stat_hi & ~clr_hi) | ev[NCH-1:REG_W];
    end
  end

  assign irq0 = (|stat_lo) | (merge_irq & (|stat_hi));
  assign irq1 = ~merge_irq & (|stat_hi);
endmodule

// File: rtl/chan_irq_status_chk.sv
module chan_irq_status_chk #(
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 12'h3D0,
  parameter logic [ADDR_W-1:0] HI_ADDR = 12'h3D4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*REG_W-1:0] done_i,
  input logic [2*REG_W-1:0] err_i,
  input logic [ADDR_W-1:0]  addr,
  input logic [REG_W-1:0]   wdata,
  input logic               wr_en,
  input logic               rd_en,
  input logic [REG_W-1:0]   rdata,
  input logic               clr_mode,
  input logic               merge_irq,
  input logic               irq0,
  input logic               irq1,
  input logic [REG_W-1:0]   stat_lo,
  input logic [REG_W-1:0]   stat_hi
);
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (({stat_hi, stat_lo} & $past(done_i | err_i)) == $past(done_i | err_i)));

  p_no_silent_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> (({stat_hi, stat_lo} & $past({stat_hi, stat_lo})) == $past({stat_hi, stat_lo})));

  p_lo_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_lo) |-> irq0);

  p_hi_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!merge_irq && (|stat_hi)) |-> irq1);

  p_idle_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_lo == '0 && stat_hi == '0) |-> (!irq0 && !irq1));

  p_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    merge_irq |-> (!irq1 && (irq0 == ((|stat_lo) || (|stat_hi)))));

  p_cor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_mode && rd_en && addr == LO_ADDR && (done_i[REG_W-1:0] | err_i[REG_W-1:0]) == '0)
    |=> stat_lo == '0);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode && wr_en && addr == LO_ADDR && (done_i[REG_W-1:0] | err_i[REG_W-1:0]) == '0)
    |=> (stat_lo & $past(wdata)) == '0);

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != LO_ADDR && addr != HI_ADDR) |-> rdata == '0);
endmodule

bind chan_irq_status chan_irq_status_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done_i(done_i), .err_i(err_i), .addr(addr),
  .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
  .clr_mode(clr_mode), .merge_irq(merge_irq), .irq0(irq0), .irq1(irq1),
  .stat_lo(stat_lo), .stat_hi(stat_hi)
);

// File: tb/tb_chan_irq_status.sv
`timescale 1ns/1ps
module tb_chan_irq_status;
  localparam logic [11:0] LO = 12'h3D0;
  localparam logic [11:0] HI = 12'h3D4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] done_i = '0, err_i = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] rdata;
  logic        clr_mode = 0, merge_irq = 0;
  logic        irq0, irq1;

  always #2.5 clk = ~clk;

  chan_irq_status dut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .err_i(err_i), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .clr_mode(clr_mode), .merge_irq(merge_irq), .irq0(irq0), .irq1(irq1)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int vec = 0, bad = 0;
  bit done_flag = 0;

  always @(negedge clk) begin
    if (rd_en && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      vec++;
      if (rdata !== it.exp) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag,
                    input logic [63:0] dn = '0, input logic [63:0] er = '0);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    addr = a; rd_en = 1; done_i = dn; err_i = er;
    step();
    rd_en = 0; done_i = '0; err_i = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [63:0] dn = '0);
    addr = a; wdata = d; wr_en = 1; done_i = dn;
    step();
    wr_en = 0; done_i = '0;
  endtask

  task automatic pulse(input logic [63:0] dn, input logic [63:0] er);
    done_i = dn; err_i = er;
    step();
    done_i = '0; err_i = '0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk(irq0, 0, "R1 irq0 after reset");
    chk(irq1, 0, "R1 irq1 after reset");
    rd(LO, 32'h0, "R1 low reset");
    rd(HI, 32'h0, "R1 high reset");
    // R2 / R3 done on channel 5
    pulse(64'h20, 64'h0);
    chk(irq0, 1, "R3 irq0 low pending");
    chk(irq1, 0, "R3 irq1 idle");
    rd(LO, 32'h20, "R2 done ch5");
    rd(LO, 32'h0, "R5 cleared by read");
    chk(irq0, 0, "R5 irq0 after clear");
    // R1 / R2 error on channel 40
    pulse(64'h0, 64'h1 << 40);
    rd(LO, 32'h0, "R1 ch40 not in low");
    chk(irq1, 1, "R3 irq1 high pending");
    chk(irq0, 0, "R3 irq0 not from high");
    merge_irq = 1; #1;
    chk(irq0, 1, "R4 merged irq0");
    chk(irq1, 0, "R4 irq1 held low");
    merge_irq = 0; #1;
    // R6 writes ignored in clear-on-read
    wr(HI, 32'hFFFF_FFFF);
    chk(irq1, 1, "R6 write kept pending");
    rd(HI, 32'h100, "R6 high after ignored write");
    rd(HI, 32'h0, "R5 high cleared by read");
    // R8 / R5 event during read
    pulse(64'h08, 64'h0);
    rd(LO, 32'h08, "R5 returned bits", 64'h80, 64'h08);
    rd(LO, 32'h88, "R8 set beats read clear");
    rd(LO, 32'h0, "R5 low empty");
    // R7 write-one-to-clear
    clr_mode = 1;
    pulse(64'h3, 64'h0);
    rd(LO, 32'h3, "R7 read shows both");
    rd(LO, 32'h3, "R7 read does not clear");
    wr(LO, 32'h1);
    rd(LO, 32'h2, "R7 one clears bit0");
    wr(LO, 32'h0);
    rd(LO, 32'h2, "R7 zero write no effect");
    wr(LO, 32'h2, 64'h2);
    rd(LO, 32'h2, "R8 set beats write clear");
    wr(LO, 32'h2);
    rd(LO, 32'h0, "R7 all cleared");
    // R9 unmapped
    pulse(64'h1 << 63, 64'h0);
    wr(12'h3D8, 32'hFFFF_FFFF);
    wr(12'h3CC, 32'hFFFF_FFFF);
    rd(HI, 32'h8000_0000, "R9 unmapped write ignored");
    rd(12'h3D8, 32'h0, "R9 unmapped read 3D8");
    rd(12'h3CC, 32'h0, "R9 unmapped read 3CC");
    merge_irq = 1; #1;
    chk(irq0, 1, "R4 merged high only");
    chk(irq1, 0, "R4 irq1 low merged");
    merge_irq = 0;
    wr(HI, 32'h8000_0000);
    chk(irq1, 0, "R7 high cleared irq1");
    repeat (2) step();
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending reads", q.size());
    end
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule